// File: doc/BRIEF.md
# Instruction Pattern Breakpoint Unit

This unit sits between the fetch queue and the execute stage of a small pipelined processor. It watches the instruction word at the head of the fetch queue. It compares that word against a pattern that the host has programmed. A mask, also host-programmed, marks which bit positions are ignored. A breakpoint can therefore select an opcode, a function code, one register field, or any mix of these. It does not depend on the program counter.

When the unit is enabled and the head word matches, the unit stalls execute in the same cycle, so the matching instruction is not consumed. It also latches a hit flag that the host can poll. The stall lasts until the host writes a clear command. The held instruction then issues exactly once, and it does not trigger again. The unit re-arms as soon as that instruction has issued, so the next matching word stops the pipeline again.

The host uses a small register bus with four word slots: pattern, mask, control and status. Reads are combinational.

Top module: `insn_bkpt_unit`

## Requirements
- R1: After reset, the pattern, mask, control and status slots all read zero, and the unit is disabled.
- R2: The host slot map is fixed. Address 0 is the pattern. Address 1 is the mask. Address 2 is control: bit 0 is enable, and bit 1 is the clear command, which is write-only and reads 0. Address 3 is status: bit 0 is the hit flag. Pattern, mask and enable read back the values written.
- R3: A word matches when every bit whose mask bit is 0 equals the pattern bit. Bits whose mask bit is 1 are ignored, and the pattern value in those positions has no effect.
- R4: When the unit is enabled, the head is valid and the head word matches, `ex_stall` is 1 in that same cycle, `ex_issue` is 0, and status bit 0 reads 1 from the next cycle on.
- R5: Once a hit is latched, `ex_stall` stays 1 and the hit flag stays 1 for as long as no clear is written and the head stays valid.
- R6: A write to address 2 with bit 1 set, made while a hit is latched, drops `ex_stall` and the hit flag from the next cycle on. The held word then issues exactly once, without matching again.
- R7: After the held word has issued, the unit is armed again, and the next matching word stalls.
- R8: While enable is 0, no word raises `ex_stall` or the hit flag.
- R9: `ex_issue` equals `fq_valid` AND NOT `ex_stall`. A word on `fq_insn` while `fq_valid` is 0 neither stalls nor sets the hit flag.
- R10: A clear written while no hit is latched has no effect. The next matching word still stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fq_valid | input | 1 | Fetch queue head holds a valid instruction |
| fq_insn | input | 32 | Instruction word at the fetch queue head |
| ex_stall | output | 1 | Holds the execute stage this cycle |
| ex_issue | output | 1 | Head instruction is consumed by execute this cycle |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Host slot select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for the selected slot |

## Verification
The bench targets the release after a clear. A design that did not suppress the re-match would stall forever on the held word. A design that never re-armed would let the next matching word run through. The bench programs pattern values that have stray bits under the mask, which catches a compare that does not apply the mask to both sides. It also checks three cases that must not trigger: a disabled unit, an invalid head word, and a clear written with no hit pending. A faulty design would show a stray stall there, or would lose its next breakpoint. Every issued word is checked against an ordered queue, so a duplicate issue or a skipped issue is caught.

// File: rtl/insn_bkpt_unit.sv
module insn_bkpt_unit #(
  parameter int IW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fq_valid,
  input  logic [IW-1:0] fq_insn,
  output logic          ex_stall,
  output logic          ex_issue,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [IW-1:0] host_wdata,
  output logic [IW-1:0] host_rdata
);

  localparam logic [AW-1:0] A_PAT  = AW'(0);
  localparam logic [AW-1:0] A_MSK  = AW'(1);
  localparam logic [AW-1:0] A_CTL  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);

  logic [IW-1:0] pat_q, msk_q;
  logic          en_q, hit_q, skip_q;

  wire wr_ctl    = host_we && host_addr == A_CTL;
  wire clr_cmd   = wr_ctl && host_wdata[1];
  wire match     = ((fq_insn ^ pat_q) & ~msk_q) == '0;
  wire fresh_hit = en_q && fq_valid && !skip_q && !hit_q && match;

  assign ex_stall = fq_valid && (hit_q || fresh_hit);
  assign ex_issue = fq_valid && !ex_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_q <= '0;
      msk_q <= '0;
      en_q  <= 1'b0;
    end else if (host_we) begin
      if (host_addr == A_PAT) pat_q <= host_wdata;
      if (host_addr == A_MSK) msk_q <= host_wdata;
      if (host_addr == A_CTL) en_q  <= host_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (clr_cmd) begin
        hit_q  <= 1'b0;
        skip_q <= hit_q;
      end else begin
        if (fresh_hit) hit_q <= 1'b1;
        if (ex_issue) skip_q <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_PAT:   host_rdata = pat_q;
      A_MSK:   host_rdata = msk_q;
      A_CTL:   host_rdata[0] = en_q;
      A_STAT:  host_rdata[0] = hit_q;
      default: host_rdata = '0;
    endcase
  end

  // R5
  hold_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !clr_cmd) |=> hit_q);

  // R5
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && fq_valid) |-> ex_stall);

  // R6
  clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> !hit_q);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !hit_q) |=> !hit_q);

  // R9
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_stall |-> fq_valid);

  // R6
  single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && ex_issue && !clr_cmd) |=> !skip_q);

endmodule

// File: tb/test_insn_bkpt_unit.sv
`timescale 1ns/1ps
module test_insn_bkpt_unit;
  logic        clk = 0, rst_n = 0;
  logic        fq_valid = 0;
  logic [31:0] fq_insn = '0;
  logic        ex_stall, ex_issue;
  logic        host_we = 0;
  logic [1:0]  host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;

  int checks = 0, fails = 0;
  logic [31:0] expq[$];

  always #10 clk = ~clk;

  insn_bkpt_unit i_insn_bkpt_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  // driver: presents one word; pushes expected issue into the scoreboard queue
  task automatic present(input logic [31:0] w, input bit exp_hit, input int hold, input string req);
    logic [31:0] r;
    @(negedge clk);
    fq_valid = 1; fq_insn = w; #1;
    chk(req, {31'd0, ex_stall}, {31'd0, exp_hit});
    if (!exp_hit) begin
      expq.push_back(w);
    end else begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk); #1;
        chk("R5", {31'd0, ex_stall}, 32'd1);
        hread(2'd3, r);
        chk("R4", r, 32'd1);
      end
      @(negedge clk);
      host_we = 1; host_addr = 2'd2; host_wdata = 32'h3; #1;
      chk("R5", {31'd0, ex_stall}, 32'd1);
      @(negedge clk);
      host_we = 0; #1;
      chk("R6", {31'd0, ex_stall}, 32'd0);
      hread(2'd3, r);
      chk("R6", r, 32'd0);
      expq.push_back(w);
    end
    @(negedge clk);
    fq_valid = 0;
  endtask

  // monitor: pops expected items on each issue
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      chk("R9", {31'd0, ex_issue}, {31'd0, fq_valid && !ex_stall});
      if (ex_issue) begin
        if (expq.size() == 0) chk("R6", fq_insn, 32'hxxxxxxxx);
        else chk("R6", fq_insn, expq.pop_front());
      end
    end
  end

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin hread(a[1:0], r); chk("R1", r, 32'd0); end
    // R8 disabled: ADDU pattern loaded, enable off
    hwrite(2'd0, 32'h0000_0021);
    hwrite(2'd1, 32'h03FF_F800);
    present(32'h0085_1821, 0, 0, "R8");
    hread(2'd3, r); chk("R8", r, 32'd0);
    // R2 readback
    hwrite(2'd2, 32'h1);
    hread(2'd0, r); chk("R2", r, 32'h0000_0021);
    hread(2'd1, r); chk("R2", r, 32'h03FF_F800);
    hread(2'd2, r); chk("R2", r, 32'h1);
    // R9 invalid head does not trigger
    @(negedge clk); fq_valid = 0; fq_insn = 32'h0085_1821; #1;
    chk("R9", {31'd0, ex_stall}, 32'd0);
    @(negedge clk); hread(2'd3, r); chk("R9", r, 32'd0);
    // R3/R4 ADDU pattern
    present(32'h2401_0005, 0, 0, "R3");
    present(32'h0085_1821, 1, 3, "R4");
    // R7 re-arm on next matching word
    present(32'h0043_0821, 1, 1, "R7");
    // rd == 1 pattern
    hwrite(2'd0, 32'h0000_0800);
    hwrite(2'd1, 32'hFFFF_07FF);
    present(32'h0043_0823, 1, 2, "R3");
    present(32'h0085_1821, 0, 0, "R3");
    // ADDU writing rd 1
    hwrite(2'd0, 32'h0000_0821);
    hwrite(2'd1, 32'h03FF_0000);
    present(32'h0043_0823, 0, 0, "R3");
    present(32'h0085_1821, 0, 0, "R3");
    present(32'h0043_0821, 1, 1, "R3");
    // R3 stray pattern bits under the mask
    hwrite(2'd0, 32'h03FF_F821);
    hwrite(2'd1, 32'h03FF_F800);
    present(32'h0085_1821, 1, 1, "R3");
    // R10 clear with no hit pending
    hwrite(2'd2, 32'h3);
    hread(2'd2, r); chk("R2", r, 32'h1);
    present(32'h0085_1821, 1, 1, "R10");
    repeat (3) @(negedge clk);
    chk("R6", expq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule